// File: doc/BRIEF.md
# PN Matched-Filter Correlator

This block is the despreading correlator of a direct-sequence spread-spectrum receiver. It is a fixed-coefficient FIR filter whose coefficients are the +1/-1 chips of a pseudo-random code. Signed samples enter a tapped delay line only on cycles where the enable input is high. Each tap is either passed through or bitwise inverted, according to its chip. A fully registered binary adder tree sums the taps. One extra leaf of that tree carries a constant equal to the number of inverted taps, so that inversion alone gives an exact negation.

The registered correlation sum goes to a comparator against a signed threshold that software or a control block supplies. The comparator raises a one-cycle detect flag that is aligned with the output valid strobe. The block accepts one sample per clock. Its latency is fixed, so a downstream demodulator can use the valid strobe directly as its sample clock enable.

Top module: `pn_correlator`

## Requirements
- R1: A sample is shifted into the delay line only on a clock edge where `in_en` is 1. On edges where `in_en` is 0 the delay line holds, so idle cycles between samples do not change any later correlation result.
- R2: Bit k of `CHIP_PATTERN` weights the sample that was accepted k enabled samples before the newest one, which is tap 0. A 1 chip weights the sample by +1 and a 0 chip weights it by -1. The default pattern is 15'b100111010011011, written MSB first.
- R3: `out_corr` is the exact signed sum of the weighted taps, with `in_sample` read as 8-bit two's complement. It stays exact without overflow over the whole input range, including every tap at -128 or every tap at +127.
- R4: `out_valid` is high for exactly one cycle, 5 clock edges after each edge that accepted a sample. It is high at no other time.
- R5: When `out_valid` is 1, `out_det` is 1 if and only if `out_corr`, read as signed, is greater than or equal to `thr`, also read as signed. Equality counts as a detect.
- R6: `out_det` is 0 whenever `out_valid` is 0.
- R7: A synchronous reset (`rst` high at a clock edge) clears the delay line and all pipeline stages. After the reset, `out_valid`, `out_det` and `out_corr` are 0, and the first sample accepted afterwards is correlated against zeros in every other tap.
- R8: With `in_en` held high, one result emerges per clock with no bubbles.
- R9: Feeding the chip sequence scaled by an amplitude A (+A for a 1 chip, -A for a 0 chip), oldest chip first and preceded by zeros, yields a peak output of 15*A at full alignment. No other output in that window is larger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Sample enable; shifts `in_sample` into the delay line |
| in_sample | input | 8 | Received sample, two's complement |
| thr | input | 12 | Detection threshold, two's complement |
| out_valid | output | 1 | Result strobe, one cycle per accepted sample |
| out_corr | output | 12 | Correlation sum, two's complement |
| out_det | output | 1 | Threshold reached on this result |

## Verification
If a tap sits at the wrong position, or carries the wrong inversion or a missing correction leaf, every valid result after that tap fills is off by a data-dependent amount. This shows up at the first compared `out_corr`, 5 cycles after the sample that reaches the tap. A broken enable path or valid pipeline shows as a strobe one cycle early or late, or as a sum that includes samples from idle cycles, within one latency of the fault. Threshold faults show on the first result that equals the threshold, and the bench forces that case on purpose.

// File: rtl/pncorr_pkg.sv
package pncorr_pkg;

   // Number of zero bits among the low n bits of a pattern word.
   function automatic int count_zero_chips(input logic [63:0] pat, input int n);
      int z;
      z = 0;
      for (int i = 0; i < n; i++) begin
         if (!pat[i]) z++;
      end
      return z;
   endfunction

   // Adder tree depth for a leaf count.
   function automatic int tree_depth(input int leaves);
      return $clog2(leaves);
   endfunction

endpackage

// File: rtl/pncorr_tapline.sv
module pncorr_tapline #(
   parameter int                 SAMPLE_W = 8,
   parameter int                 CHIPS    = 15,
   parameter logic [CHIPS-1:0]   PATTERN  = '1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [SAMPLE_W-1:0]     din,
   output logic [CHIPS*SAMPLE_W-1:0] taps_flat,
   output logic                    vld
);

   logic [SAMPLE_W-1:0] chain [CHIPS];

   always_ff @(posedge clk) begin
      if (rst) begin
         vld <= 1'b0;
         for (int k = 0; k < CHIPS; k++) chain[k] <= '0;
      end else begin
         vld <= en;
         if (en) begin
            chain[0] <= din;
            for (int k = 1; k < CHIPS; k++) chain[k] <= chain[k-1];
         end
      end
   end

   // Per-tap sign: pass through or invert; the +1 of each negation is added later.
   for (genvar k = 0; k < CHIPS; k++) begin : g_tap
      if (PATTERN[k]) begin : g_pos
         assign taps_flat[k*SAMPLE_W +: SAMPLE_W] = chain[k];
      end else begin : g_neg
         assign taps_flat[k*SAMPLE_W +: SAMPLE_W] = ~chain[k];
      end
   end

   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(taps_flat)); // R1

endmodule

// File: rtl/pncorr_addtree.sv
module pncorr_addtree #(
   parameter int IN_W   = 8,
   parameter int LEAVES = 16,
   localparam int LEVELS = pncorr_pkg::tree_depth(LEAVES),
   localparam int OUT_W  = IN_W + LEVELS
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [LEAVES*IN_W-1:0]   leaves_flat,
   input  logic                     in_vld,
   output logic signed [OUT_W-1:0]  sum,
   output logic                     out_vld
);

   localparam int NP = 1 << LEVELS;

   if (LEAVES < 2) begin : g_bad_leaves
      $error("pncorr_addtree needs at least two leaves");
   end

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int WL = IN_W + l;
      localparam int NN = NP >> l;
      logic signed [WL-1:0] node [NN];
      logic                 v;

      if (l == 0) begin : g_leaf
         assign v = in_vld;
         for (genvar i = 0; i < NN; i++) begin : g_in
            if (i < LEAVES) begin : g_used
               assign node[i] = $signed(leaves_flat[i*IN_W +: IN_W]);
            end else begin : g_pad
               assign node[i] = '0;
            end
         end
      end else begin : g_add
         always_ff @(posedge clk) begin
            if (rst) begin
               v <= 1'b0;
               for (int i = 0; i < NN; i++) node[i] <= '0;
            end else begin
               v <= g_lvl[l-1].v;
               for (int i = 0; i < NN; i++) begin
                  node[i] <= WL'(g_lvl[l-1].node[2*i]) + WL'(g_lvl[l-1].node[2*i+1]);
               end
            end
         end
      end
   end

   assign sum     = g_lvl[LEVELS].node[0];
   assign out_vld = g_lvl[LEVELS].v;

endmodule

// File: rtl/pncorr_detect.sv
module pncorr_detect #(
   parameter int CORR_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_in,
   input  logic signed [CORR_W-1:0] sum_in,
   input  logic signed [CORR_W-1:0] thr,
   output logic                     out_valid,
   output logic signed [CORR_W-1:0] out_corr,
   output logic                     out_det
);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_det   <= 1'b0;
         out_corr  <= '0;
      end else begin
         out_valid <= vld_in;
         out_det   <= vld_in && (sum_in >= thr);
         if (vld_in) out_corr <= sum_in;
      end
   end

   AST_DET_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
      out_det |-> out_valid); // R6

   AST_DET_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_det == (out_corr >= $past(thr)))); // R5

   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && !out_det && out_corr == '0)); // R7

endmodule

// File: rtl/pn_correlator.sv
module pn_correlator #(
   parameter int               SAMPLE_W     = 8,
   parameter int               CHIPS        = 15,
   parameter logic [CHIPS-1:0] CHIP_PATTERN = 15'b100111010011011,
   parameter int               CORR_W       = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_en,
   input  logic [SAMPLE_W-1:0]      in_sample,
   input  logic signed [CORR_W-1:0] thr,
   output logic                     out_valid,
   output logic signed [CORR_W-1:0] out_corr,
   output logic                     out_det
);
   import pncorr_pkg::*;

   localparam int LEAVES  = CHIPS + 1;
   localparam int LEVELS  = tree_depth(LEAVES);
   localparam int TREE_W  = SAMPLE_W + LEVELS;
   localparam int NEG_CNT = count_zero_chips(64'(CHIP_PATTERN), CHIPS);
   localparam int MAX_MAG = CHIPS * (1 << (SAMPLE_W - 1));

   if (CHIPS < 2 || CHIPS > 63) begin : g_bad_chips
      $error("CHIPS must lie in 2..63");
   end
   if (CORR_W < TREE_W) begin : g_bad_width
      $error("CORR_W too narrow for the adder tree growth");
   end
   if (NEG_CNT >= (1 << (SAMPLE_W - 1))) begin : g_bad_neg
      $error("negation count does not fit one leaf");
   end

   logic [CHIPS*SAMPLE_W-1:0]  taps_flat;
   logic                       tap_vld;
   logic [LEAVES*SAMPLE_W-1:0] leaves_flat;
   logic signed [TREE_W-1:0]   tree_sum;
   logic                       tree_vld;
   logic signed [CORR_W-1:0]   tree_sum_x;

   pncorr_tapline #(
      .SAMPLE_W (SAMPLE_W),
      .CHIPS    (CHIPS),
      .PATTERN  (CHIP_PATTERN)
   ) u_tapline (
      .clk       (clk),
      .rst       (rst),
      .en        (in_en),
      .din       (in_sample),
      .taps_flat (taps_flat),
      .vld       (tap_vld)
   );

   // Correction leaf restores +1 for every inverted tap.
   assign leaves_flat = {SAMPLE_W'(NEG_CNT), taps_flat};

   pncorr_addtree #(
      .IN_W   (SAMPLE_W),
      .LEAVES (LEAVES)
   ) u_tree (
      .clk         (clk),
      .rst         (rst),
      .leaves_flat (leaves_flat),
      .in_vld      (tap_vld),
      .sum         (tree_sum),
      .out_vld     (tree_vld)
   );

   assign tree_sum_x = CORR_W'(tree_sum);

   pncorr_detect #(
      .CORR_W (CORR_W)
   ) u_detect (
      .clk       (clk),
      .rst       (rst),
      .vld_in    (tree_vld),
      .sum_in    (tree_sum_x),
      .thr       (thr),
      .out_valid (out_valid),
      .out_corr  (out_corr),
      .out_det   (out_det)
   );

   AST_CORR_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_corr) <= MAX_MAG && int'(out_corr) >= -MAX_MAG)); // R3

endmodule

// File: tb/sim_pn_correlator.sv
module sim_pn_correlator;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 15;
   localparam int LAT  = 6;
   localparam logic [N-1:0] PAT = 15'b100111010011011;

   logic clk = 1'b0;
   logic rst;
   logic in_en;
   logic [7:0] in_sample;
   logic signed [11:0] thr;
   logic out_valid;
   logic signed [11:0] out_corr;
   logic out_det;

   int checks = 0;
   int errors = 0;
   int bch [N];
   bit pv [LAT];
   int ps [LAT];
   int peak_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   pn_correlator u0 (
      .clk(clk), .rst(rst), .in_en(in_en), .in_sample(in_sample), .thr(thr),
      .out_valid(out_valid), .out_corr(out_corr), .out_det(out_det)
   );

   function automatic int model_sum();
      int s;
      s = 0;
      for (int k = 0; k < N; k++) s += PAT[k] ? bch[k] : -bch[k];
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic r, input logic e, input logic [7:0] x);
      rst = r; in_en = e; in_sample = x;
      @(posedge clk);
      for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; ps[i] = ps[i-1]; end
      if (r) begin
         for (int k = 0; k < N; k++) bch[k] = 0;
         for (int i = 0; i < LAT; i++) begin pv[i] = 0; ps[i] = 0; end
      end else if (e) begin
         for (int k = N-1; k > 0; k--) bch[k] = bch[k-1];
         bch[0] = int'($signed(x));
         pv[0] = 1; ps[0] = model_sum();
      end else begin
         pv[0] = 0;
      end
      @(negedge clk);
      chk(out_valid == pv[LAT-1], "R4 valid timing", int'(out_valid), int'(pv[LAT-1]));
      if (pv[LAT-1]) begin
         chk(int'(out_corr) == ps[LAT-1], "R2/R3 correlation sum", int'(out_corr), ps[LAT-1]);
         chk(out_det == (ps[LAT-1] >= int'(thr)), "R5 threshold detect",
             int'(out_det), int'(ps[LAT-1] >= int'(thr)));
         if (int'(out_corr) > peak_seen) peak_seen = int'(out_corr);
      end else begin
         chk(out_det == 1'b0, "R6 detect without valid", int'(out_det), 0);
      end
   endtask

   task automatic send_pattern(input int amp);
      for (int i = 0; i < N; i++) step(0, 1, 8'(0));
      for (int i = 0; i < LAT; i++) step(0, 0, 8'(0));
      peak_seen = -100000;
      for (int i = N-1; i >= 0; i--) step(0, 1, 8'(PAT[i] ? amp : -amp));
      for (int i = 0; i < LAT; i++) step(0, 0, 8'(0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      thr = 12'sd100;
      for (int i = 0; i < LAT; i++) begin pv[i] = 0; ps[i] = 0; end
      for (int k = 0; k < N; k++) bch[k] = 0;
      peak_seen = -100000;
      step(1, 0, 8'(0));
      step(1, 0, 8'(0));
      chk(out_valid == 0 && out_det == 0, "R7 reset outputs", int'(out_valid), 0);
      chk(out_corr == 0, "R7 reset corr", int'(out_corr), 0);

      // R7: first sample after reset sees zeros elsewhere; R2: tap 0 weight
      step(0, 1, 8'd40);
      for (int i = 0; i < LAT; i++) step(0, 0, 8'(0));

      // R8: continuous enable, random data
      for (int i = 0; i < 300; i++) step(0, 1, 8'($urandom));
      // R1: random enables with idle gaps, random thresholds between bursts
      for (int b = 0; b < 20; b++) begin
         for (int i = 0; i < LAT; i++) step(0, 0, 8'($urandom));
         thr = 12'($signed(12'($urandom_range(0, 1200))) - 12'sd600);
         for (int i = 0; i < 40; i++) step(0, 1'($urandom), 8'($urandom));
      end
      for (int i = 0; i < LAT; i++) step(0, 0, 8'(0));

      // R3 extremes
      for (int i = 0; i < N + LAT; i++) step(0, 1, 8'h80);
      for (int i = 0; i < N + LAT; i++) step(0, 1, 8'h7f);

      // R9 peak, and R5 equality at the peak
      thr = 12'sd750;
      send_pattern(50);
      chk(peak_seen == 750, "R9 peak amplitude 50", peak_seen, 750);
      thr = 12'sd751;
      send_pattern(50);
      chk(peak_seen == 750, "R9 peak repeat", peak_seen, 750);
      thr = 12'sd0;
      send_pattern(127);
      chk(peak_seen == 1905, "R9/R3 peak amplitude 127", peak_seen, 1905);
      send_pattern(-128);
      chk(peak_seen < 1920, "R3 anti-peak window", peak_seen, 1920);

      // R7: reset in mid-stream clears pipeline
      for (int i = 0; i < 3; i++) step(0, 1, 8'($urandom));
      step(1, 1, 8'd9);
      chk(out_valid == 0 && out_corr == 0, "R7 mid-stream reset", int'(out_corr), 0);
      step(0, 1, 8'hf0);
      for (int i = 0; i < LAT + 2; i++) step(0, 0, 8'(0));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule